// File: doc/BRIEF.md
# Dual-Standard Zero-Crossing FSK Demodulator

This block recovers the 1200 bit/s asynchronous bit stream carried by a phase-coherent two-tone FSK signal. The tone has already been band-limited and squared by an analog comparator. Each level change of the squared input is a zero crossing. The block counts system clocks between consecutive crossings. It then decides whether each half-cycle belongs to the mark (logic 1) tone or the space (logic 0) tone.

One discriminator serves two tone plans:
- 1200/2200 Hz with ±1% tolerance (Bell 202 style).
- 1300/2100 Hz with ±1.5% tolerance (V.23 style).

A clock-select level picks the timebase the block runs on. A level of 1 means a 3,579,545 Hz clock and a level of 0 means a 455,000 Hz clock. The decision limits therefore come from a small computed table indexed by tone plan and timebase. Half-cycles outside the tolerance band are discarded. Accepted decisions pass through a 3-of-5 majority vote before they reach the registered output.

The block is intended to sit behind the analog front end of a caller-identity receiver. A UART-style framer that takes the bit stream follows it.

Top module: `fsk_zc_demod`

## Requirements
- R1: While `rst` is high and after it is released, `data_out` is 1 (mark). The vote history holds five mark decisions.
- R2: Every level change of `fsk_in`, rising or falling, ends one half-period measurement. The measurement is the number of clock cycles since the previous level change, and the count restarts at 1 on the cycle after the change.
- R3: With `clk_sel`=1 and `mode_v23`=0, half-periods of 813 clocks (2200 Hz) decide space and half-periods of 1491 clocks (1200 Hz) decide mark.
- R4: With `clk_sel`=0 and `mode_v23`=0, half-periods of 103 clocks decide space and half-periods of 190 clocks decide mark.
- R5: `mode_v23`=1 selects the 1300/2100 Hz plan with ±1.5% tolerance. At `clk_sel`=0, 108 clocks decide space and 175 clocks decide mark. A 145-clock half-period is space in the 1200/2200 Hz plan and mark in the 1300/2100 Hz plan.
- R6: A half-period below the low limit or above the high limit leaves the vote history unchanged and so leaves `data_out` unchanged.
- R7: The limits are inclusive, and a half-period equal to the midpoint decides space. For clock frequency F, mark and space tones fm and fs, and tolerance t in parts per thousand, the limits are computed in integer arithmetic:
  - low = floor(F·1000 / (2·fs·(1000+t)))
  - high = ceil(F·(1000+t) / (2·fm·1000))
  - mid = (floor(F/(2·fm)) + floor(F/(2·fs))) / 2
  
  At 455 kHz in the 1200/2200 Hz plan these give low = 102, mid = 146 and high = 192.
- R8: `data_out` is 1 exactly when at least 3 of the 5 most recent accepted decisions are mark. Two space decisions among marks do not change it, and three do.
- R9: The period counter saturates at 2^CNT_W−1 (4095 by default). An input that stops toggling produces no decisions, and the first crossing after a saturated wait is rejected.
- R10: When an input crossing completes the third agreeing vote, `data_out` takes the new value on the fourth rising clock edge at which the new input level is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (3.58 MHz or 455 kHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| mode_v23 | input | 1 | Tone plan: 0 = 1200/2200 Hz, 1 = 1300/2100 Hz |
| clk_sel | input | 1 | Timebase: 1 = 3,579,545 Hz, 0 = 455,000 Hz |
| fsk_in | input | 1 | Comparator-sliced FSK tone, asynchronous |
| data_out | output | 1 | Demodulated bit after majority filter, registered |

## Verification
Steady tones at the nominal half-periods of both plans and both timebases show that mark and space are told apart. A 145-clock tone decides differently under the two plans, which shows that the plan selection reaches the midpoint. Runs of tones one clock inside and one clock outside each limit, and at the midpoint and one above it, pin down inclusive bounds and the tie rule. Two or three isolated opposite half-cycles separate a correct 3-of-5 vote from a thinner or wider one. A long silent gap sized so that a wrapping counter would land in band separates saturation from overflow.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  localparam longint BELL_MARK_HZ  = 1200;
  localparam longint BELL_SPACE_HZ = 2200;
  localparam longint BELL_TOL_PM   = 10;
  localparam longint V23_MARK_HZ   = 1300;
  localparam longint V23_SPACE_HZ  = 2100;
  localparam longint V23_TOL_PM    = 15;

  // shortest accepted half-period (fast space tone, minus tolerance)
  function automatic longint hp_low(input longint fclk, input longint fspace, input longint tol);
    return (fclk * 1000) / (2 * fspace * (1000 + tol));
  endfunction

  // longest accepted half-period (slow mark tone, plus tolerance), rounded up
  function automatic longint hp_high(input longint fclk, input longint fmark, input longint tol);
    return (fclk * (1000 + tol) + 2 * fmark * 1000 - 1) / (2 * fmark * 1000);
  endfunction

  // decision point between the two nominal half-periods
  function automatic longint hp_mid(input longint fclk, input longint fmark, input longint fspace);
    return ((fclk / (2 * fmark)) + (fclk / (2 * fspace))) / 2;
  endfunction

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_stb
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sr;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[SYNC_STAGES-2:0], din};
      prev <= sr[MSB];
    end
  end

  assign edge_stb = sr[MSB] ^ prev;
endmodule

// File: rtl/fsk_halfper_meas.sv
module fsk_halfper_meas #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_stb,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      meas_cnt <= CNT_MAX;
    end else if (edge_stb) begin
      meas_cnt <= CNT_ONE;
    end else if (meas_cnt != CNT_MAX) begin
      meas_cnt <= meas_cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/fsk_thresh_sel.sv
module fsk_thresh_sel
  import fsk_demod_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int CLK_HI_HZ = 3579545,
  parameter int CLK_LO_HZ = 455000
) (
  input  logic             mode_v23,
  input  logic             clk_sel,
  output logic [CNT_W-1:0] lim_lo,
  output logic [CNT_W-1:0] lim_mid,
  output logic [CNT_W-1:0] lim_hi
);
  localparam int NTAB = 4;

  logic [CNT_W-1:0] lo_tab  [NTAB];
  logic [CNT_W-1:0] mid_tab [NTAB];
  logic [CNT_W-1:0] hi_tab  [NTAB];

  for (genvar gm = 0; gm < 2; gm++) begin : g_plan
    for (genvar gc = 0; gc < 2; gc++) begin : g_clk
      localparam longint FCLK = (gc == 1) ? longint'(CLK_HI_HZ) : longint'(CLK_LO_HZ);
      localparam longint FM   = (gm == 1) ? V23_MARK_HZ  : BELL_MARK_HZ;
      localparam longint FS   = (gm == 1) ? V23_SPACE_HZ : BELL_SPACE_HZ;
      localparam longint TOL  = (gm == 1) ? V23_TOL_PM   : BELL_TOL_PM;
      assign lo_tab [gm*2+gc] = CNT_W'(hp_low (FCLK, FS, TOL));
      assign mid_tab[gm*2+gc] = CNT_W'(hp_mid (FCLK, FM, FS));
      assign hi_tab [gm*2+gc] = CNT_W'(hp_high(FCLK, FM, TOL));
    end
  end

  logic [1:0] idx;
  assign idx = {mode_v23, clk_sel};

  always_comb begin
    lim_lo  = lo_tab[idx];
    lim_mid = mid_tab[idx];
    lim_hi  = hi_tab[idx];
  end
endmodule

// File: rtl/fsk_classify.sv
module fsk_classify #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] meas,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_mid,
  input  logic [CNT_W-1:0] lim_hi,
  output logic             in_band,
  output logic             is_mark
);
  always_comb begin
    in_band = (meas >= lim_lo) && (meas <= lim_hi);
    is_mark = (meas > lim_mid);
  end
endmodule

// File: rtl/fsk_vote_filter.sv
module fsk_vote_filter #(
  parameter int WIN      = 5,
  parameter int VOTE_MIN = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           bit_in,
  output logic [WIN-1:0] hist,
  output logic           vote_out
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) begin
      ones = ones + CW'(hist[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '1;
      vote_out <= 1'b1;
    end else begin
      if (push) begin
        hist <= {hist[WIN-2:0], bit_in};
      end
      vote_out <= (ones >= CW'(VOTE_MIN));
    end
  end
endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod #(
  parameter int CNT_W       = 12,
  parameter int CLK_HI_HZ   = 3579545,
  parameter int CLK_LO_HZ   = 455000,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_WIN    = 5,
  parameter int VOTE_MIN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_v23,
  input  logic clk_sel,
  input  logic fsk_in,
  output logic data_out
);
  logic                edge_stb;
  logic [CNT_W-1:0]    meas_cnt;
  logic [CNT_W-1:0]    lim_lo, lim_mid, lim_hi;
  logic                in_band, is_mark;
  logic [VOTE_WIN-1:0] hist;

  fsk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(fsk_in), .edge_stb(edge_stb)
  );

  fsk_halfper_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .edge_stb(edge_stb), .meas_cnt(meas_cnt)
  );

  fsk_thresh_sel #(.CNT_W(CNT_W), .CLK_HI_HZ(CLK_HI_HZ), .CLK_LO_HZ(CLK_LO_HZ)) u_thr (
    .mode_v23(mode_v23), .clk_sel(clk_sel),
    .lim_lo(lim_lo), .lim_mid(lim_mid), .lim_hi(lim_hi)
  );

  fsk_classify #(.CNT_W(CNT_W)) u_cls (
    .meas(meas_cnt), .lim_lo(lim_lo), .lim_mid(lim_mid), .lim_hi(lim_hi),
    .in_band(in_band), .is_mark(is_mark)
  );

  fsk_vote_filter #(.WIN(VOTE_WIN), .VOTE_MIN(VOTE_MIN)) u_vote (
    .clk(clk), .rst(rst), .push(edge_stb && in_band), .bit_in(is_mark),
    .hist(hist), .vote_out(data_out)
  );
endmodule

// File: rtl/fsk_zc_demod_chk.sv
module fsk_zc_demod_chk #(
  parameter int CNT_W    = 12,
  parameter int VOTE_WIN = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                data_out,
  input logic                edge_stb,
  input logic                in_band,
  input logic [CNT_W-1:0]    meas_cnt,
  input logic [VOTE_WIN-1:0] hist
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic seen_clk = 1'b0;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R1: reset leaves a mark output and a full mark history
  assert_reset_mark_R1: assert property (@(posedge clk)
    (seen_clk && $past(rst)) |-> (data_out && (hist == '1)));

  // R2: a crossing restarts the half-period count
  assert_count_restart_R2: assert property (@(posedge clk) disable iff (rst)
    edge_stb |=> (meas_cnt == CONE));

  // R6: a rejected half-period leaves the history alone
  assert_reject_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_stb && !in_band) |=> $stable(hist));

  // R8: the output moves only after the vote history moved
  assert_out_follows_vote_R8: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && (data_out != $past(data_out))) |-> ($past(hist) != $past(hist, 2)));

  // R9: a silent input keeps the counter pinned at its ceiling
  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (rst)
    ((meas_cnt == CMAX) && !edge_stb) |=> (meas_cnt == CMAX));
endmodule

bind fsk_zc_demod fsk_zc_demod_chk #(.CNT_W(CNT_W), .VOTE_WIN(VOTE_WIN)) u_chk (
  .clk(clk), .rst(rst), .data_out(data_out), .edge_stb(edge_stb),
  .in_band(in_band), .meas_cnt(meas_cnt), .hist(hist)
);

// File: tb/fsk_zc_demod_bench.sv
`timescale 1ns/1ps
module fsk_zc_demod_bench;
  localparam int CNT_MAX = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_v23 = 1'b0;
  logic clk_sel = 1'b0;
  logic fsk_in = 1'b0;
  logic data_out;

  int checks = 0;
  int fails = 0;
  bit seen_low, seen_high;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsk_zc_demod u_fsk_zc_demod (
    .clk(clk), .rst(rst), .mode_v23(mode_v23), .clk_sel(clk_sel),
    .fsk_in(fsk_in), .data_out(data_out)
  );

  // limits from the requirement formulas (R7)
  function automatic longint f_lo(longint fc, longint fs, longint t);
    return (fc * 1000) / (2 * fs * (1000 + t));
  endfunction
  function automatic longint f_hi(longint fc, longint fm, longint t);
    return (fc * (1000 + t) + 2 * fm * 1000 - 1) / (2 * fm * 1000);
  endfunction
  function automatic longint f_mid(longint fc, longint fm, longint fs);
    return ((fc / (2 * fm)) + (fc / (2 * fs))) / 2;
  endfunction

  // behavioural reference model
  bit in_dly[$];
  int m_cnt;
  bit m_hist[$];
  bit m_out;

  function automatic bit m_vote();
    int n = 0;
    foreach (m_hist[i]) n += m_hist[i];
    return n >= 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      in_dly = '{0, 0, 0};
      m_cnt  = CNT_MAX;
      m_hist = '{1, 1, 1, 1, 1};
      m_out  = 1'b1;
    end else begin
      longint fc, fm, fs, t, lo, hi, mid;
      bit nxt;
      nxt = m_vote();
      fc = clk_sel ? 3579545 : 455000;
      fm = mode_v23 ? 1300 : 1200;
      fs = mode_v23 ? 2100 : 2200;
      t  = mode_v23 ? 15 : 10;
      lo = f_lo(fc, fs, t); hi = f_hi(fc, fm, t); mid = f_mid(fc, fm, fs);
      // crossing seen two samples late, compared against the level before it
      if (in_dly[1] != in_dly[0]) begin
        if (m_cnt >= lo && m_cnt <= hi) begin
          m_hist.push_back(m_cnt > mid);
          void'(m_hist.pop_front());
        end
        m_cnt = 1;
      end else if (m_cnt < CNT_MAX) begin
        m_cnt++;
      end
      void'(in_dly.pop_front());
      in_dly.push_back(fsk_in);
      m_out = nxt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (data_out !== m_out) begin
        fails++;
        $display("FAIL R2 cycle model: data_out=%b expected=%b at %0t", data_out, m_out, $time);
      end
      if (data_out === 1'b0) seen_low = 1'b1;
      if (data_out === 1'b1) seen_high = 1'b1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tone(input int half, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fsk_in = ~fsk_in;
      repeat (half - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 during reset", data_out, 1'b1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after reset", data_out, 1'b1);

    // R4: 455 kHz, 1200/2200 Hz plan
    tone(190, 10); check("R4 mark 190", data_out, 1'b1);
    tone(103, 10); check("R4 space 103", data_out, 1'b0);
    tone(190, 10); check("R4 mark again", data_out, 1'b1);

    // R8: two isolated spaces are outvoted, three are not
    seen_low = 0;
    tone(103, 2); tone(190, 6);
    check("R8 two spaces no change", seen_low, 1'b0);
    tone(103, 4); check("R8 three spaces flip", data_out, 1'b0);
    tone(190, 8); check("R8 back to mark", data_out, 1'b1);

    // R6: too short and too long half-periods are rejected
    seen_low = 0;
    tone(60, 6); tone(190, 4);
    check("R6 short halves ignored", seen_low, 1'b0);
    tone(103, 8);
    seen_high = 0;
    tone(250, 4); tone(103, 4);
    check("R6 long halves ignored", seen_high, 1'b0);

    // R7: inclusive limits 102/192, midpoint 146 is space
    tone(193, 5); check("R7 hi+1 rejected", data_out, 1'b0);
    tone(192, 5); check("R7 hi accepted", data_out, 1'b1);
    tone(101, 5); check("R7 lo-1 rejected", data_out, 1'b1);
    tone(102, 5); check("R7 lo accepted", data_out, 1'b0);
    tone(146, 5); check("R7 mid is space", data_out, 1'b0);
    tone(147, 5); check("R7 mid+1 is mark", data_out, 1'b1);

    // R5: plan selection moves the decision point
    tone(145, 8); check("R5 145 space in 1200/2200 plan", data_out, 1'b0);
    mode_v23 = 1'b1;
    tone(145, 8); check("R5 145 mark in 1300/2100 plan", data_out, 1'b1);
    tone(108, 10); check("R5 space 108", data_out, 1'b0);
    tone(175, 10); check("R5 mark 175", data_out, 1'b1);
    mode_v23 = 1'b0;

    // R9: gap sized so a wrapping counter would read ~105 (space)
    seen_low = 0;
    repeat (4026) @(negedge clk);
    check("R9 idle no decisions", seen_low, 1'b0);
    tone(103, 3); check("R9 first edge after gap rejected", data_out, 1'b1);
    tone(103, 4); check("R9 space after gap", data_out, 1'b0);

    // R10: latency from completing crossing to output
    tone(103, 4);
    tone(190, 3);
    begin
      int n = 0;
      @(negedge clk);
      fsk_in = ~fsk_in;
      while (data_out !== 1'b1 && n < 12) begin
        @(negedge clk);
        n++;
      end
      checks++;
      if (n != 4) begin
        fails++;
        $display("FAIL R10 latency: actual=%0d expected=4", n);
      end
    end

    // R3: 3.58 MHz timebase, 1200/2200 Hz plan
    clk_sel = 1'b1;
    tone(813, 6); check("R3 space 813", data_out, 1'b0);
    tone(1491, 6); check("R3 mark 1491", data_out, 1'b1);

    finish_run();
  end
endmodule